// File: doc/BRIEF.md
# Write-Once Snooping Coherence Controller

This block keeps one small direct-mapped cache coherent with its peers on a shared snooping bus. It tracks a tag and one of four line states per set: Invalid, Valid, Reserved and Dirty. It holds no data. A processor load or store is accepted on the request port. The block checks the indexed line and either completes locally or issues one or two bus commands through a request/grant handshake. It also watches the bus traffic of the other caches on the snoop port and adjusts its own lines.

The first store to a Valid line is sent to memory as a single-word write-through. The line then becomes Reserved: exclusive and still equal to memory. Later stores move it to Dirty with no bus traffic. A Dirty line is written back only when it is evicted. When another cache reads or writes a Dirty line, this block raises a flush pulse that asks for the line to be supplied.

Processor machine states and transitions:
- **IDLE** waits for a request. On a load hit or a store hit it goes to **DONE**. The one exception is a store to a Valid line, which goes to **WTHRU**. On a miss it goes to **EVICT** if the victim is Dirty, and to **FILL** otherwise.
- **EVICT** issues the write-back and then goes to **FILL**. If a snoop has already cleaned the victim, it goes to **FILL** at once.
- **FILL** issues a Bus Read or a Bus Write and goes to **DONE** on grant.
- **WTHRU** issues the write-through and goes to **DONE** on grant. If a snoop has invalidated the line meanwhile, it falls back to **FILL** as a store miss.
- **DONE** pulses completion and returns to **IDLE**.

Snoop transitions:
- A Bus Read moves Dirty to Valid with a flush, moves Reserved to Valid, and leaves Valid as it is.
- A Bus Write or a write-through moves any held line to Invalid, with a flush if the line was Dirty.
- A snooped Write Back changes nothing.

Top module: `wonce_coh_ctrl`

## Requirements
- R1: While reset is low and in the first cycle after it, bus_req, cpu_busy and snp_flush are 0 and every line is Invalid, so the first access to any address misses.
- R2: A load miss issues bus_cmd 0 (Bus Read) at the requested address and fills the line Valid, with cpu_done one cycle after the grant edge. A load hit issues nothing, and cpu_done is high in the cycle after the request edge.
- R3: A store miss issues bus_cmd 1 (Bus Write) at the requested address and fills the line Dirty.
- R4: A store that hits a Valid line issues bus_cmd 2 (write-through) at that address and leaves the line Reserved.
- R5: A store that hits a Reserved line makes it Dirty with no bus command. A store that hits a Dirty line keeps it Dirty with no bus command. Both complete one cycle after the request edge.
- R6: A snooped bus_cmd 1 or 2 that matches a held line makes that line Invalid. If the line was Dirty, snp_flush is high in the next cycle.
- R7: A snooped bus_cmd 0 that matches a line moves Dirty to Valid with snp_flush high in the next cycle, moves Reserved to Valid with no flush, and leaves Valid unchanged. A flush occurs only after a snooped command other than 3.
- R8: The address index is cpu_addr[1:0] with the default of 4 sets. A miss whose victim is Dirty first issues bus_cmd 3 (Write Back) at the victim's address, then the fill command. A Valid or Reserved victim is dropped with no write-back.
- R9: Once raised, bus_req stays high with the same bus_cmd and bus_addr until bus_gnt is seen.
- R10: A cpu_req that arrives while cpu_busy is high is ignored. Each accepted request produces exactly one cpu_done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Request pulse, taken only when not busy |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | AW | Line address of the request |
| cpu_busy | output | 1 | A request is in progress |
| cpu_done | output | 1 | One-cycle completion pulse |
| bus_req | output | 1 | Bus command pending |
| bus_cmd | output | 2 | 0 Bus Read, 1 Bus Write, 2 write-through, 3 Write Back |
| bus_addr | output | AW | Line address of the bus command |
| bus_gnt | input | 1 | Grant; the command is taken in a cycle with bus_req and bus_gnt high |
| snp_valid | input | 1 | A peer's command is on the bus |
| snp_cmd | input | 2 | Snooped command, same coding as bus_cmd |
| snp_addr | input | AW | Snooped line address |
| snp_flush | output | 1 | A Dirty line here was hit by the snooped read or write |

## Verification
Each result has a fixed cycle of arrival:
- A hit completes in the cycle after the request edge.
- A bus command appears in the cycle after acceptance (or after the preceding write-back) and is taken in the cycle it is granted. cpu_done follows one cycle after that grant edge.
- A flush from the peer appears in the same cycle as that cpu_done.

The scoreboard samples the bus and the flush outputs on every falling edge and pops one expected item per observed grant or flush. It checks hit and miss completion latencies against those counts. After each operation it idles three cycles and then requires the queue to be empty, so a missing or extra transaction is caught before the next stimulus.

// File: rtl/wonce_pkg.sv
package wonce_pkg;
    typedef enum logic [1:0] {
        LN_INV = 2'd0,
        LN_VAL = 2'd1,
        LN_RSV = 2'd2,
        LN_DRT = 2'd3
    } line_st_e;

    localparam logic [1:0] BC_READ  = 2'd0;
    localparam logic [1:0] BC_WRITE = 2'd1;
    localparam logic [1:0] BC_WTHRU = 2'd2;
    localparam logic [1:0] BC_WBACK = 2'd3;

    typedef enum logic [2:0] {
        PS_IDLE,
        PS_EVICT,
        PS_FILL,
        PS_WTHRU,
        PS_DONE
    } proc_st_e;
endpackage

// File: rtl/wonce_line_store.sv
module wonce_line_store
    import wonce_pkg::*;
#(
    parameter int SETS = 4,
    parameter int TAGW = 6,
    localparam int IDXW = $clog2(SETS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [IDXW-1:0] pa_idx,
    output line_st_e        pa_st,
    output logic [TAGW-1:0] pa_tag,
    input  logic [IDXW-1:0] sb_idx,
    output line_st_e        sb_st,
    output logic [TAGW-1:0] sb_tag,
    input  logic            sw_en,
    input  logic [IDXW-1:0] sw_idx,
    input  line_st_e        sw_st,
    input  logic            pw_en,
    input  logic [IDXW-1:0] pw_idx,
    input  logic [TAGW-1:0] pw_tag,
    input  line_st_e        pw_st
);
    line_st_e        st_q  [SETS];
    logic [TAGW-1:0] tag_q [SETS];

    // The processor-side write is applied last, so it wins on the same set.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < SETS; i++) begin
                st_q[i]  <= LN_INV;
                tag_q[i] <= '0;
            end
        end else begin
            if (sw_en) begin
                st_q[sw_idx] <= sw_st;
            end
            if (pw_en) begin
                st_q[pw_idx]  <= pw_st;
                tag_q[pw_idx] <= pw_tag;
            end
        end
    end

    assign pa_st  = st_q[pa_idx];
    assign pa_tag = tag_q[pa_idx];
    assign sb_st  = st_q[sb_idx];
    assign sb_tag = tag_q[sb_idx];
endmodule

// File: rtl/wonce_snoop_dec.sv
module wonce_snoop_dec
    import wonce_pkg::*;
(
    input  logic       snp_valid,
    input  logic [1:0] snp_cmd,
    input  logic       tag_hit,
    input  line_st_e   cur_st,
    output logic       upd,
    output line_st_e   nxt_st,
    output logic       flush_now
);
    always_comb begin
        upd       = 1'b0;
        nxt_st    = cur_st;
        flush_now = 1'b0;
        if (snp_valid && tag_hit && cur_st != LN_INV) begin
            unique case (snp_cmd)
                BC_READ: begin
                    if (cur_st == LN_DRT || cur_st == LN_RSV) begin
                        upd       = 1'b1;
                        nxt_st    = LN_VAL;
                        flush_now = (cur_st == LN_DRT);
                    end
                end
                BC_WRITE, BC_WTHRU: begin
                    upd       = 1'b1;
                    nxt_st    = LN_INV;
                    flush_now = (cur_st == LN_DRT);
                end
                default: begin
                    // A peer's write-back leaves the line as it is.
                    upd = 1'b0;
                end
            endcase
        end
    end
endmodule

// File: rtl/wonce_proc_fsm.sv
module wonce_proc_fsm
    import wonce_pkg::*;
#(
    parameter int AW   = 8,
    parameter int SETS = 4,
    localparam int IDXW = $clog2(SETS),
    localparam int TAGW = AW - IDXW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cpu_req,
    input  logic            cpu_we,
    input  logic [AW-1:0]   cpu_addr,
    output logic            cpu_busy,
    output logic            cpu_done,
    output logic            bus_req,
    output logic [1:0]      bus_cmd,
    output logic [AW-1:0]   bus_addr,
    input  logic            bus_gnt,
    input  logic            snp_valid,
    output logic [IDXW-1:0] rd_idx,
    input  line_st_e        line_st,
    input  logic [TAGW-1:0] line_tag,
    output logic            pw_en,
    output logic [IDXW-1:0] pw_idx,
    output logic [TAGW-1:0] pw_tag,
    output line_st_e        pw_st
);
    proc_st_e        ps_q, ps_d;
    logic [AW-1:0]   addr_q;
    logic            we_q;
    logic [AW-1:0]   cur_addr;
    logic [TAGW-1:0] cur_tag;
    logic            tag_hit;
    logic            taken;

    assign cur_addr = (ps_q == PS_IDLE) ? cpu_addr : addr_q;
    assign cur_tag  = cur_addr[AW-1:IDXW];
    assign rd_idx   = cur_addr[IDXW-1:0];
    assign tag_hit  = (line_tag == cur_tag) && (line_st != LN_INV);
    assign taken    = bus_req && bus_gnt;

    // State register and request capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ps_q   <= PS_IDLE;
            addr_q <= '0;
            we_q   <= 1'b0;
        end else begin
            ps_q <= ps_d;
            if (ps_q == PS_IDLE && cpu_req) begin
                addr_q <= cpu_addr;
                we_q   <= cpu_we;
            end
        end
    end

    // Next state
    always_comb begin
        ps_d = ps_q;
        unique case (ps_q)
            PS_IDLE: begin
                if (cpu_req) begin
                    if (tag_hit) begin
                        ps_d = (cpu_we && line_st == LN_VAL) ? PS_WTHRU : PS_DONE;
                    end else if (line_st == LN_DRT) begin
                        ps_d = PS_EVICT;
                    end else begin
                        ps_d = PS_FILL;
                    end
                end
            end
            PS_EVICT: begin
                if (line_st != LN_DRT || taken) begin
                    ps_d = PS_FILL;
                end
            end
            PS_FILL: begin
                if (taken) begin
                    ps_d = PS_DONE;
                end
            end
            PS_WTHRU: begin
                if (!(tag_hit && line_st == LN_VAL)) begin
                    ps_d = PS_FILL;
                end else if (taken) begin
                    ps_d = PS_DONE;
                end
            end
            PS_DONE: ps_d = PS_IDLE;
            default: ps_d = PS_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        bus_req  = 1'b0;
        bus_cmd  = BC_READ;
        bus_addr = addr_q;
        pw_en    = 1'b0;
        pw_idx   = rd_idx;
        pw_tag   = cur_tag;
        pw_st    = LN_INV;
        cpu_busy = (ps_q != PS_IDLE);
        cpu_done = (ps_q == PS_DONE);
        unique case (ps_q)
            PS_IDLE: begin
                if (cpu_req && tag_hit && cpu_we && line_st == LN_RSV) begin
                    pw_en = 1'b1;
                    pw_st = LN_DRT;
                end
            end
            PS_EVICT: begin
                bus_req  = (line_st == LN_DRT);
                bus_cmd  = BC_WBACK;
                bus_addr = {line_tag, rd_idx};
            end
            PS_FILL: begin
                bus_req = 1'b1;
                bus_cmd = we_q ? BC_WRITE : BC_READ;
                if (taken) begin
                    pw_en = 1'b1;
                    pw_st = we_q ? LN_DRT : LN_VAL;
                end
            end
            PS_WTHRU: begin
                bus_req = tag_hit && (line_st == LN_VAL);
                bus_cmd = BC_WTHRU;
                if (taken) begin
                    pw_en = 1'b1;
                    pw_st = LN_RSV;
                end
            end
            PS_DONE: begin
                pw_en = 1'b0;
            end
            default: begin
                pw_en = 1'b0;
            end
        endcase
    end

    // R9
    hold_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_gnt && !snp_valid) |=>
            (bus_req && $stable(bus_cmd) && $stable(bus_addr)));

    // R8
    wb_then_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_gnt && bus_cmd == BC_WBACK) |=>
            (bus_req && (bus_cmd == BC_READ || bus_cmd == BC_WRITE)));

    // R10
    one_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done |=> (!cpu_done && !cpu_busy));
endmodule

// File: rtl/wonce_coh_ctrl.sv
module wonce_coh_ctrl
    import wonce_pkg::*;
#(
    parameter int AW   = 8,
    parameter int SETS = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cpu_req,
    input  logic          cpu_we,
    input  logic [AW-1:0] cpu_addr,
    output logic          cpu_busy,
    output logic          cpu_done,
    output logic          bus_req,
    output logic [1:0]    bus_cmd,
    output logic [AW-1:0] bus_addr,
    input  logic          bus_gnt,
    input  logic          snp_valid,
    input  logic [1:0]    snp_cmd,
    input  logic [AW-1:0] snp_addr,
    output logic          snp_flush
);
    localparam int IDXW = $clog2(SETS);
    localparam int TAGW = AW - IDXW;

    logic [IDXW-1:0] rd_idx;
    line_st_e        rd_st;
    logic [TAGW-1:0] rd_tag;
    logic            pw_en;
    logic [IDXW-1:0] pw_idx;
    logic [TAGW-1:0] pw_tag;
    line_st_e        pw_st;

    logic [IDXW-1:0] sn_idx;
    logic [TAGW-1:0] sn_tag_in;
    line_st_e        sn_st;
    logic [TAGW-1:0] sn_tag;
    logic            sn_hit;
    logic            sw_en;
    line_st_e        sw_st;
    logic            flush_now;
    logic            flush_q;

    assign sn_idx    = snp_addr[IDXW-1:0];
    assign sn_tag_in = snp_addr[AW-1:IDXW];
    assign sn_hit    = (sn_tag == sn_tag_in);

    wonce_line_store #(.SETS(SETS), .TAGW(TAGW)) store_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .pa_idx (rd_idx),
        .pa_st  (rd_st),
        .pa_tag (rd_tag),
        .sb_idx (sn_idx),
        .sb_st  (sn_st),
        .sb_tag (sn_tag),
        .sw_en  (sw_en),
        .sw_idx (sn_idx),
        .sw_st  (sw_st),
        .pw_en  (pw_en),
        .pw_idx (pw_idx),
        .pw_tag (pw_tag),
        .pw_st  (pw_st)
    );

    wonce_snoop_dec snoop_i (
        .snp_valid (snp_valid),
        .snp_cmd   (snp_cmd),
        .tag_hit   (sn_hit),
        .cur_st    (sn_st),
        .upd       (sw_en),
        .nxt_st    (sw_st),
        .flush_now (flush_now)
    );

    wonce_proc_fsm #(.AW(AW), .SETS(SETS)) fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_req   (cpu_req),
        .cpu_we    (cpu_we),
        .cpu_addr  (cpu_addr),
        .cpu_busy  (cpu_busy),
        .cpu_done  (cpu_done),
        .bus_req   (bus_req),
        .bus_cmd   (bus_cmd),
        .bus_addr  (bus_addr),
        .bus_gnt   (bus_gnt),
        .snp_valid (snp_valid),
        .rd_idx    (rd_idx),
        .line_st   (rd_st),
        .line_tag  (rd_tag),
        .pw_en     (pw_en),
        .pw_idx    (pw_idx),
        .pw_tag    (pw_tag),
        .pw_st     (pw_st)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flush_q <= 1'b0;
        end else begin
            flush_q <= flush_now;
        end
    end
    assign snp_flush = flush_q;

    // R1
    rst_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!bus_req && !cpu_busy && !snp_flush));

    // R6
    inval_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && (snp_cmd == BC_WRITE || snp_cmd == BC_WTHRU) &&
         sn_hit && sn_st == LN_DRT) |=> snp_flush);

    // R7
    flush_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        snp_flush |-> ($past(snp_valid) && $past(snp_cmd) != BC_WBACK));
endmodule

// File: tb/wonce_coh_ctrl_tb_top.sv
module wonce_coh_ctrl_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic       a_req = 0, a_we = 0, b_req = 0, b_we = 0;
    logic [7:0] a_addr = 0, b_addr = 0;
    logic       a_busy, a_done, a_breq, a_flush;
    logic       b_busy, b_done, b_breq, b_flush;
    logic [1:0] a_cmd, b_cmd;
    logic [7:0] a_baddr, b_baddr;
    logic       a_gnt, b_gnt;
    logic       stall_a = 0;

    assign a_gnt = a_breq && !stall_a;
    assign b_gnt = b_breq && !a_breq;

    wonce_coh_ctrl #(.AW(8), .SETS(4)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(a_req), .cpu_we(a_we), .cpu_addr(a_addr),
        .cpu_busy(a_busy), .cpu_done(a_done),
        .bus_req(a_breq), .bus_cmd(a_cmd), .bus_addr(a_baddr), .bus_gnt(a_gnt),
        .snp_valid(b_gnt), .snp_cmd(b_cmd), .snp_addr(b_baddr),
        .snp_flush(a_flush)
    );

    wonce_coh_ctrl #(.AW(8), .SETS(4)) peer_i (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(b_req), .cpu_we(b_we), .cpu_addr(b_addr),
        .cpu_busy(b_busy), .cpu_done(b_done),
        .bus_req(b_breq), .bus_cmd(b_cmd), .bus_addr(b_baddr), .bus_gnt(b_gnt),
        .snp_valid(a_gnt), .snp_cmd(a_cmd), .snp_addr(a_baddr),
        .snp_flush(b_flush)
    );

    // kind: 0 read, 1 write, 2 write-through, 3 write-back, 4 flush
    typedef struct {
        int    kind;
        int    src;
        int    addr;
        string rq;
    } ev_t;
    ev_t   expq[$];
    int    checks = 0;
    int    errors = 0;
    string cur_rq = "R1";
    bit    fin = 0;
    int    cyc = 0;

    task automatic expect_ev(input int kind, input int src, input int addr, input string rq);
        ev_t e;
        e.kind = kind; e.src = src; e.addr = addr; e.rq = rq;
        expq.push_back(e);
    endtask

    task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    task automatic got(input int kind, input int src, input int addr);
        ev_t e;
        checks++;
        if (expq.size() == 0) begin
            errors++;
            $display("FAIL %s unexpected event actual kind %0d src %0d addr %0h expected none",
                     cur_rq, kind, src, addr);
        end else begin
            e = expq.pop_front();
            if (e.kind != kind || e.src != src || e.addr != addr) begin
                errors++;
                $display("FAIL %s event actual kind %0d src %0d addr %0h expected kind %0d src %0d addr %0h",
                         e.rq, kind, src, addr, e.kind, e.src, e.addr);
            end
        end
    endtask

    // Monitor: scoreboard pops one expected item per grant or flush
    always @(negedge clk) begin
        if (rst_n && !fin) begin
            if (a_breq && a_gnt) got(int'(a_cmd), 0, int'(a_baddr));
            if (b_breq && b_gnt) got(int'(b_cmd), 1, int'(b_baddr));
            if (a_flush) got(4, 0, 0);
            if (b_flush) got(4, 1, 0);
        end
    end

    task automatic drive(input int who, input bit req, input bit we, input logic [7:0] addr);
        if (who == 0) begin a_req = req; a_we = we; a_addr = addr; end
        else begin b_req = req; b_we = we; b_addr = addr; end
    endtask

    function automatic bit done_of(input int who);
        return (who == 0) ? a_done : b_done;
    endfunction

    task automatic drain(input string rq);
        repeat (3) @(negedge clk);
        chk(expq.size() == 0, rq, "queue drained, items left", expq.size(), 0);
        expq.delete();
    endtask

    task automatic wait_done(input int who, input string rq, output int lat);
        int n = 0;
        while (!done_of(who) && n < 40) begin
            @(negedge clk);
            n++;
        end
        lat = n;
        chk(done_of(who), rq, "cpu_done seen", int'(done_of(who)), 1);
    endtask

    task automatic op(input int who, input bit we, input logic [7:0] addr,
                      input string rq, output int lat);
        cur_rq = rq;
        @(negedge clk);
        drive(who, 1'b1, we, addr);
        @(negedge clk);
        drive(who, 1'b0, 1'b0, 8'h00);
        wait_done(who, rq, lat);
        drain(rq);
    endtask

    initial begin
        int lat;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state at the ports
        chk(!a_breq && !b_breq, "R1", "bus_req after reset", int'(a_breq | b_breq), 0);
        chk(!a_busy && !b_busy, "R1", "cpu_busy after reset", int'(a_busy | b_busy), 0);
        chk(!a_flush && !b_flush, "R1", "snp_flush after reset", int'(a_flush | b_flush), 0);

        // R2 load miss after reset (R1: lines start Invalid)
        expect_ev(0, 0, 'h10, "R2");
        op(0, 0, 8'h10, "R2", lat);
        chk(lat == 1, "R2", "load miss latency", lat, 1);
        // R2 load hit
        op(0, 0, 8'h10, "R2", lat);
        chk(lat == 0, "R2", "load hit latency", lat, 0);
        // peer read of a Valid line: no flush (R7)
        expect_ev(0, 1, 'h10, "R7");
        op(1, 0, 8'h10, "R7", lat);
        // R4 first store to Valid: write-through, peer invalidated (R6)
        expect_ev(2, 0, 'h10, "R4");
        op(0, 1, 8'h10, "R4", lat);
        // R5 Reserved to Dirty silently, then Dirty stays Dirty
        op(0, 1, 8'h10, "R5", lat);
        chk(lat == 0, "R5", "store hit latency", lat, 0);
        op(0, 1, 8'h10, "R5", lat);
        // R6 peer misses (was invalidated); R7 Dirty owner flushes, goes Valid
        expect_ev(0, 1, 'h10, "R6");
        expect_ev(4, 0, 0, "R7");
        op(1, 0, 8'h10, "R6", lat);
        // R7 owner is Valid again: store writes through
        expect_ev(2, 0, 'h10, "R7");
        op(0, 1, 8'h10, "R7", lat);
        // R7 Reserved snoops read: to Valid, no flush
        expect_ev(0, 1, 'h10, "R7");
        op(1, 0, 8'h10, "R7", lat);
        expect_ev(2, 0, 'h10, "R7");
        op(0, 1, 8'h10, "R7", lat);
        // R8 Reserved victim dropped silently
        expect_ev(0, 0, 'h14, "R8");
        op(0, 0, 8'h14, "R8", lat);
        // R3 store miss with Valid victim
        expect_ev(1, 0, 'h20, "R3");
        op(0, 1, 8'h20, "R3", lat);
        op(0, 1, 8'h20, "R3", lat);
        // R8 Dirty victim: write-back then fill
        expect_ev(3, 0, 'h20, "R8");
        expect_ev(0, 0, 'h30, "R8");
        op(0, 0, 8'h30, "R8", lat);
        chk(lat == 2, "R8", "evict plus fill latency", lat, 2);
        // R3 peer store miss, then R7 flush on read
        expect_ev(1, 1, 'h31, "R3");
        op(1, 1, 8'h31, "R3", lat);
        expect_ev(0, 0, 'h31, "R7");
        expect_ev(4, 1, 0, "R7");
        op(0, 0, 8'h31, "R7", lat);
        expect_ev(2, 1, 'h31, "R4");
        op(1, 1, 8'h31, "R4", lat);
        expect_ev(0, 0, 'h31, "R6");
        op(0, 0, 8'h31, "R6", lat);
        // R6 snooped Bus Write on Dirty: flush and invalidate
        expect_ev(1, 1, 'h42, "R3");
        op(1, 1, 8'h42, "R3", lat);
        expect_ev(1, 0, 'h42, "R6");
        expect_ev(4, 1, 0, "R6");
        op(0, 1, 8'h42, "R6", lat);
        expect_ev(0, 1, 'h42, "R6");
        expect_ev(4, 0, 0, "R7");
        op(1, 0, 8'h42, "R6", lat);

        // R10 request while busy is ignored
        cur_rq = "R10";
        expect_ev(0, 0, 'h55, "R10");
        @(negedge clk);
        drive(0, 1'b1, 1'b0, 8'h55);
        @(negedge clk);
        drive(0, 1'b1, 1'b1, 8'h66);
        chk(a_busy, "R10", "busy while second request", int'(a_busy), 1);
        @(negedge clk);
        drive(0, 1'b0, 1'b0, 8'h00);
        wait_done(0, "R10", lat);
        drain("R10");
        chk(!a_done, "R10", "single done pulse", int'(a_done), 0);
        expect_ev(0, 0, 'h66, "R10");
        op(0, 0, 8'h66, "R10", lat);

        // R9 request held stable while grant withheld
        cur_rq = "R9";
        stall_a = 1'b1;
        expect_ev(0, 0, 'h77, "R9");
        @(negedge clk);
        drive(0, 1'b1, 1'b0, 8'h77);
        @(negedge clk);
        drive(0, 1'b0, 1'b0, 8'h00);
        repeat (3) @(negedge clk);
        chk(a_breq && a_cmd == 2'd0 && a_baddr == 8'h77, "R9", "held request addr",
            int'(a_baddr), 'h77);
        chk(!a_done, "R9", "no done before grant", int'(a_done), 0);
        stall_a = 1'b0;
        wait_done(0, "R9", lat);
        drain("R9");

        fin = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000 && !fin) begin
            fin = 1;
            errors++;
            checks++;
            $display("FAIL watchdog actual %0d cycles expected completion", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule